// File: doc/BRIEF.md
# Landing-Pad Expectation Tracker

This block keeps the one-bit forward-edge control-flow state of a hart: whether the next instruction is required to be a landing pad. When an indirect jump whose target register is not an exempt link register retires at a privilege level that has landing pads enabled, the state becomes "expected". A landing-pad instruction then clears it. While the state is "expected", any other instruction raises a software-check fault in the same cycle and is held back from retiring.

The block also stores the state whenever control leaves the interrupted context. A supervisor trap saves the state in a supervisor-level saved bit. A machine trap saves it in a machine-level saved bit. Entry to debug mode saves it in a debug saved bit. In every one of these cases the live state is then cleared. A trap return at a given level copies that level's saved bit back into the live state and zeroes the saved bit.

The pipeline drives the block with one instruction word per cycle and event strobes. The saved bits are outputs that the surrounding status registers include in their read values.

Top module: `cfi_lp_tracker`

## Requirements
- R1: While reset is active and just after it is released, `elp_q`, `spelp`, `mpelp`, `dbg_elp` and `fault` are all 0, and `fault_cause` is 0.
- R2: The landing pad is a word with bits [6:0] = 7'b0010111 and bits [11:7] = 0. Bits [31:12] are a label and are ignored. A landing pad presented with `elp_q`=1 raises no fault, and after that clock edge `elp_q` is 0. Any other instruction that retires also leaves `elp_q` at 0, unless R5 applies.
- R3: A fault is raised when all of the following hold: `insn_valid`=1, `elp_q`=1, landing pads are enabled at the current privilege, the word is not a landing pad, and no event strobe is set. The fault is raised combinationally in that same cycle. It drives `fault_cause` to 18, and after the edge `elp_q` is still 1.
- R4: No fault is raised when `elp_q`=0 or when landing pads are disabled at the current privilege. The privilege encoding is 0=user, 1=supervisor, 3=machine. Code 2 counts as disabled. The enable inputs are `lp_en_u`, `lp_en_s` and `lp_en_m`.
- R5: Suppose an instruction retires with `jump_valid`=1, landing pads are enabled at the current privilege, and `jump_rs1` is not 1, 5 or 7. Then `elp_q` is 1 after the edge. Under any other condition a retiring instruction leaves `elp_q` at 0.
- R6: `trap_s` copies `elp_q` into `spelp` and clears `elp_q` at the next edge.
- R7: `trap_m` copies `elp_q` into `mpelp` and clears `elp_q` at the next edge.
- R8: `dbg_enter` copies `elp_q` into `dbg_elp` and clears `elp_q` at the next edge.
- R9: Event priority is `dbg_enter` > `trap_m` > `trap_s` > `ret_m` > `ret_s` > retirement. Only the winning event takes effect. Any event strobe suppresses the fault.
- R10: `ret_m` loads `elp_q` from `mpelp` and zeroes `mpelp`. `ret_s` does the same with `spelp`. Both take effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid | input | 1 | An instruction is presented for execution this cycle |
| insn_word | input | 32 | Instruction bits |
| priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| lp_en_u | input | 1 | Landing pads enabled in user mode |
| lp_en_s | input | 1 | Landing pads enabled in supervisor mode |
| lp_en_m | input | 1 | Landing pads enabled in machine mode |
| jump_valid | input | 1 | Presented instruction is an indirect jump or call |
| jump_rs1 | input | 5 | Target register index of that jump |
| trap_s | input | 1 | Trap entry handled at supervisor level |
| trap_m | input | 1 | Trap entry handled at machine level |
| dbg_enter | input | 1 | Debug-mode entry |
| ret_s | input | 1 | Return from supervisor trap |
| ret_m | input | 1 | Return from machine trap |
| fault | output | 1 | Landing-pad fault request; blocks retirement |
| fault_cause | output | 6 | Exception cause, 18 while `fault` is set |
| elp_q | output | 1 | Live landing-pad-expected state |
| spelp | output | 1 | Saved state for supervisor traps |
| mpelp | output | 1 | Saved state for machine traps |
| dbg_elp | output | 1 | Saved state for debug entry |

## Verification
`fault` and `fault_cause` are combinational. The bench therefore samples them a quarter period after it drives the inputs on the falling edge, while the same inputs are still held. Each state output (`elp_q` and the three saved bits) is due one rising edge after its stimulus, so the bench reads them 1 ns after that edge, before it drives anything new. Every row of the stimulus table, and every directed case, pairs one sample taken at each of these two points.

// File: rtl/cfi_lp_pkg.sv
// Shared definitions for the landing-pad tracker.
// Assumes a 32-bit base instruction encoding and 5-bit register indices.
package cfi_lp_pkg;

    typedef enum logic [1:0] {
        PRV_U   = 2'd0,
        PRV_S   = 2'd1,
        PRV_RSV = 2'd2,
        PRV_M   = 2'd3
    } priv_e;

    // Which update the state registers perform this cycle (priority resolved).
    typedef enum logic [2:0] {
        UPD_HOLD,
        UPD_DBG,
        UPD_TRAP_M,
        UPD_TRAP_S,
        UPD_RET_M,
        UPD_RET_S,
        UPD_RETIRE
    } upd_e;

    localparam int unsigned OPC_W      = 7;
    localparam logic [6:0]  OPC_AUIPC  = 7'b0010111;
    localparam int unsigned SWCHK_CODE = 18;

    // Target registers that never arm the landing-pad expectation.
    localparam int unsigned NUM_EXEMPT = 3;
    localparam int unsigned EXEMPT_REGS [NUM_EXEMPT] = '{1, 5, 7};

endpackage

// File: rtl/cfi_lp_decode.sv
// Instruction-side decode: landing-pad match, per-level enable select and
// the arming condition of indirect jumps.
// Assumes the opcode occupies the low OPC_W bits, directly followed by rd.
module cfi_lp_decode
    import cfi_lp_pkg::*;
#(
    parameter int unsigned INSN_W    = 32,
    parameter int unsigned REG_IDX_W = 5
) (
    input  logic [INSN_W-1:0]    insn_word,
    input  priv_e                priv,
    input  logic                 lp_en_u,
    input  logic                 lp_en_s,
    input  logic                 lp_en_m,
    input  logic                 jump_valid,
    input  logic [REG_IDX_W-1:0] jump_rs1,
    output logic                 is_lpad,
    output logic                 lvl_en,
    output logic                 arm
);
    localparam int unsigned          FIXED_W   = OPC_W + REG_IDX_W;
    localparam logic [INSN_W-1:0]    PAD_MASK  = INSN_W'((64'd1 << FIXED_W) - 64'd1);
    localparam logic [INSN_W-1:0]    PAD_MATCH = INSN_W'(OPC_AUIPC);

    logic [NUM_EXEMPT-1:0] exempt_hit;

    // Compare the fixed (non-label) bits against the landing-pad pattern.
    assign is_lpad = (insn_word & PAD_MASK) == PAD_MATCH;

    // One comparator per exempt link register.
    for (genvar gi = 0; gi < NUM_EXEMPT; gi++) begin : g_exempt
        assign exempt_hit[gi] = (jump_rs1 == REG_IDX_W'(EXEMPT_REGS[gi]));
    end

    // Select the enable that belongs to the current privilege level.
    always_comb begin
        case (priv)
            PRV_U:   lvl_en = lp_en_u;
            PRV_S:   lvl_en = lp_en_s;
            PRV_M:   lvl_en = lp_en_m;
            default: lvl_en = 1'b0;
        endcase
    end

    // A non-exempt indirect jump at an enabled level demands a landing pad.
    assign arm = jump_valid && lvl_en && !(|exempt_hit);

endmodule

// File: rtl/cfi_lp_arbiter.sv
// Resolves the event priority for the cycle and decides the fault.
// Assumes the event strobes and the presented instruction are those of the
// same cycle; any event strobe means the instruction does not retire normally.
module cfi_lp_arbiter
    import cfi_lp_pkg::*;
(
    input  logic insn_valid,
    input  logic elp,
    input  logic lvl_en,
    input  logic is_lpad,
    input  logic dbg_enter,
    input  logic trap_m,
    input  logic trap_s,
    input  logic ret_m,
    input  logic ret_s,
    output logic fault,
    output upd_e upd
);
    logic any_event;

    assign any_event = dbg_enter | trap_m | trap_s | ret_m | ret_s;

    // Fault only on a normal attempt to execute a non-pad while one is expected.
    assign fault = insn_valid && elp && lvl_en && !is_lpad && !any_event;

    // Fixed priority: debug, machine trap, supervisor trap, returns, retire.
    always_comb begin
        if (dbg_enter)                upd = UPD_DBG;
        else if (trap_m)              upd = UPD_TRAP_M;
        else if (trap_s)              upd = UPD_TRAP_S;
        else if (ret_m)               upd = UPD_RET_M;
        else if (ret_s)               upd = UPD_RET_S;
        else if (insn_valid && !fault) upd = UPD_RETIRE;
        else                          upd = UPD_HOLD;
    end

endmodule

// File: rtl/cfi_lp_state.sv
// Holds the live expectation bit and the three saved copies.
// Assumes exactly one update kind per cycle, chosen by the arbiter.
module cfi_lp_state
    import cfi_lp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  upd_e upd,
    input  logic arm,
    output logic elp_q,
    output logic spelp,
    output logic mpelp,
    output logic dbg_elp
);
    // Apply the selected save, restore or retire update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elp_q   <= 1'b0;
            spelp   <= 1'b0;
            mpelp   <= 1'b0;
            dbg_elp <= 1'b0;
        end else begin
            case (upd)
                UPD_DBG: begin
                    dbg_elp <= elp_q;
                    elp_q   <= 1'b0;
                end
                UPD_TRAP_M: begin
                    mpelp <= elp_q;
                    elp_q <= 1'b0;
                end
                UPD_TRAP_S: begin
                    spelp <= elp_q;
                    elp_q <= 1'b0;
                end
                UPD_RET_M: begin
                    elp_q <= mpelp;
                    mpelp <= 1'b0;
                end
                UPD_RET_S: begin
                    elp_q <= spelp;
                    spelp <= 1'b0;
                end
                UPD_RETIRE: elp_q <= arm;
                default:    elp_q <= elp_q;
            endcase
        end
    end

endmodule

// File: rtl/cfi_lp_tracker.sv
// Top of the landing-pad tracker: decode, priority arbitration and state.
// Assumes one instruction presented per cycle and mutually consistent strobes
// from the trap and debug logic; the fault is combinational.
module cfi_lp_tracker
    import cfi_lp_pkg::*;
#(
    parameter int unsigned INSN_W    = 32,
    parameter int unsigned REG_IDX_W = 5,
    parameter int unsigned CAUSE_W   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 insn_valid,
    input  logic [INSN_W-1:0]    insn_word,
    input  logic [1:0]           priv,
    input  logic                 lp_en_u,
    input  logic                 lp_en_s,
    input  logic                 lp_en_m,
    input  logic                 jump_valid,
    input  logic [REG_IDX_W-1:0] jump_rs1,
    input  logic                 trap_s,
    input  logic                 trap_m,
    input  logic                 dbg_enter,
    input  logic                 ret_s,
    input  logic                 ret_m,
    output logic                 fault,
    output logic [CAUSE_W-1:0]   fault_cause,
    output logic                 elp_q,
    output logic                 spelp,
    output logic                 mpelp,
    output logic                 dbg_elp
);
    localparam logic [CAUSE_W-1:0] CAUSE_VAL = CAUSE_W'(SWCHK_CODE);

    logic is_lpad;
    logic lvl_en;
    logic arm;
    upd_e upd;

    cfi_lp_decode #(
        .INSN_W    (INSN_W),
        .REG_IDX_W (REG_IDX_W)
    ) u_decode (
        .insn_word  (insn_word),
        .priv       (priv_e'(priv)),
        .lp_en_u    (lp_en_u),
        .lp_en_s    (lp_en_s),
        .lp_en_m    (lp_en_m),
        .jump_valid (jump_valid),
        .jump_rs1   (jump_rs1),
        .is_lpad    (is_lpad),
        .lvl_en     (lvl_en),
        .arm        (arm)
    );

    cfi_lp_arbiter u_arb (
        .insn_valid (insn_valid),
        .elp        (elp_q),
        .lvl_en     (lvl_en),
        .is_lpad    (is_lpad),
        .dbg_enter  (dbg_enter),
        .trap_m     (trap_m),
        .trap_s     (trap_s),
        .ret_m      (ret_m),
        .ret_s      (ret_s),
        .fault      (fault),
        .upd        (upd)
    );

    cfi_lp_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (upd),
        .arm     (arm),
        .elp_q   (elp_q),
        .spelp   (spelp),
        .mpelp   (mpelp),
        .dbg_elp (dbg_elp)
    );

    // Report the software-check cause only alongside a fault.
    assign fault_cause = fault ? CAUSE_VAL : '0;

endmodule

// File: rtl/cfi_lp_tracker_chk.sv
// Property checker for cfi_lp_tracker, attached by bind below.
// Assumes the default 32-bit instruction and 6-bit cause widths.
module cfi_lp_tracker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        insn_valid,
    input logic [31:0] insn_word,
    input logic        trap_s,
    input logic        trap_m,
    input logic        dbg_enter,
    input logic        ret_s,
    input logic        ret_m,
    input logic        fault,
    input logic [5:0]  fault_cause,
    input logic        elp_q,
    input logic        spelp,
    input logic        mpelp,
    input logic        dbg_elp
);
    logic any_ev;
    assign any_ev = trap_s | trap_m | dbg_enter | ret_s | ret_m;

    AST_FAULT_NEEDS_ELP: assert property (@(posedge clk) disable iff (!rst_n) fault |-> elp_q); // R3
    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) fault |-> fault_cause == 6'd18); // R3
    AST_FAULT_KEEPS_ELP: assert property (@(posedge clk) disable iff (!rst_n) fault |=> elp_q); // R3
    AST_PAD_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n) (insn_valid && (insn_word & 32'hFFF) == 32'h017) |-> !fault); // R2
    AST_EVENT_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n) any_ev |-> !fault); // R9
    AST_DBG_SAVE: assert property (@(posedge clk) disable iff (!rst_n) dbg_enter |=> (dbg_elp == $past(elp_q)) && !elp_q); // R8
    AST_TRAP_M_SAVE: assert property (@(posedge clk) disable iff (!rst_n) (trap_m && !dbg_enter) |=> (mpelp == $past(elp_q)) && !elp_q); // R7
    AST_TRAP_S_SAVE: assert property (@(posedge clk) disable iff (!rst_n) (trap_s && !trap_m && !dbg_enter) |=> (spelp == $past(elp_q)) && !elp_q); // R6
    AST_RET_M_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (ret_m && !trap_s && !trap_m && !dbg_enter) |=> (elp_q == $past(mpelp)) && !mpelp); // R10
    AST_RET_S_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (ret_s && !ret_m && !trap_s && !trap_m && !dbg_enter) |=> (elp_q == $past(spelp)) && !spelp); // R10

endmodule

bind cfi_lp_tracker cfi_lp_tracker_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .insn_valid  (insn_valid),
    .insn_word   (insn_word),
    .trap_s      (trap_s),
    .trap_m      (trap_m),
    .dbg_enter   (dbg_enter),
    .ret_s       (ret_s),
    .ret_m       (ret_m),
    .fault       (fault),
    .fault_cause (fault_cause),
    .elp_q       (elp_q),
    .spelp       (spelp),
    .mpelp       (mpelp),
    .dbg_elp     (dbg_elp)
);

// File: tb/cfi_lp_tracker_tb.sv
// Self-checking bench: a table of one-cycle vectors, then directed cases.
module cfi_lp_tracker_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 5000;

    localparam logic [31:0] NOP = 32'h0000_0013;
    localparam logic [31:0] JR  = 32'h0005_0067;
    localparam logic [31:0] PAD = 32'h1234_5017;
    localparam logic [31:0] AU1 = 32'h0000_1097;

    // ev = {dbg_enter, trap_m, trap_s, ret_m, ret_s}; en = {m, s, u}
    typedef struct packed {
        logic [3:0]  req;
        logic        val;
        logic [31:0] word;
        logic [1:0]  priv;
        logic [2:0]  en;
        logic        jmp;
        logic [4:0]  rs1;
        logic [4:0]  ev;
        logic        xf;
        logic        xe;
        logic        xs;
        logic        xm;
        logic        xd;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{4'd5,  1'b1, JR,  2'd3, 3'b100, 1'b1, 5'd10, 5'b00000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 arm
        '{4'd3,  1'b1, NOP, 2'd3, 3'b100, 1'b0, 5'd0,  5'b00000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 fault
        '{4'd2,  1'b1, PAD, 2'd3, 3'b100, 1'b0, 5'd0,  5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 pad
        '{4'd5,  1'b1, JR,  2'd3, 3'b100, 1'b1, 5'd1,  5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 x1
        '{4'd5,  1'b1, JR,  2'd3, 3'b100, 1'b1, 5'd5,  5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 x5
        '{4'd5,  1'b1, JR,  2'd3, 3'b100, 1'b1, 5'd7,  5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 x7
        '{4'd4,  1'b1, JR,  2'd0, 3'b100, 1'b1, 5'd6,  5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 user off
        '{4'd5,  1'b1, JR,  2'd0, 3'b001, 1'b1, 5'd6,  5'b00000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 user on
        '{4'd4,  1'b1, NOP, 2'd0, 3'b100, 1'b0, 5'd0,  5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 no check
        '{4'd5,  1'b1, JR,  2'd1, 3'b010, 1'b1, 5'd12, 5'b00000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 sup
        '{4'd6,  1'b1, NOP, 2'd1, 3'b010, 1'b0, 5'd0,  5'b00100, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R6 R9
        '{4'd10, 1'b0, NOP, 2'd1, 3'b010, 1'b0, 5'd0,  5'b00001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R10 ret_s
        '{4'd7,  1'b0, NOP, 2'd3, 3'b100, 1'b0, 5'd0,  5'b01000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R7
        '{4'd10, 1'b0, NOP, 2'd3, 3'b100, 1'b0, 5'd0,  5'b00010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R10 ret_m
        '{4'd9,  1'b1, NOP, 2'd3, 3'b100, 1'b0, 5'd0,  5'b11000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R9 R8
        '{4'd4,  1'b1, NOP, 2'd3, 3'b100, 1'b0, 5'd0,  5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 elp low
        '{4'd10, 1'b0, NOP, 2'd3, 3'b100, 1'b0, 5'd0,  5'b00010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R10 zero
        '{4'd5,  1'b1, JR,  2'd3, 3'b100, 1'b1, 5'd3,  5'b00000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R5
        '{4'd3,  1'b1, AU1, 2'd3, 3'b100, 1'b0, 5'd0,  5'b00000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R3 rd!=0
        '{4'd6,  1'b0, NOP, 2'd3, 3'b100, 1'b0, 5'd0,  5'b00100, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}  // R6
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        insn_valid, jump_valid;
    logic [31:0] insn_word;
    logic [1:0]  priv;
    logic        lp_en_u, lp_en_s, lp_en_m;
    logic [4:0]  jump_rs1;
    logic        trap_s, trap_m, dbg_enter, ret_s, ret_m;
    logic        fault, elp_q, spelp, mpelp, dbg_elp;
    logic [5:0]  fault_cause;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfi_lp_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
        .priv(priv), .lp_en_u(lp_en_u), .lp_en_s(lp_en_s), .lp_en_m(lp_en_m),
        .jump_valid(jump_valid), .jump_rs1(jump_rs1), .trap_s(trap_s), .trap_m(trap_m),
        .dbg_enter(dbg_enter), .ret_s(ret_s), .ret_m(ret_m), .fault(fault),
        .fault_cause(fault_cause), .elp_q(elp_q), .spelp(spelp), .mpelp(mpelp),
        .dbg_elp(dbg_elp)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one vector for one cycle; check the fault mid-cycle, state after edge.
    task automatic step(input vec_t v);
        string tag;
        tag = $sformatf("R%0d", v.req);
        @(negedge clk);
        insn_valid = v.val;  insn_word = v.word;  priv = v.priv;
        {lp_en_m, lp_en_s, lp_en_u} = v.en;
        jump_valid = v.jmp;  jump_rs1 = v.rs1;
        {dbg_enter, trap_m, trap_s, ret_m, ret_s} = v.ev;
        #(CLK_PERIOD/4);
        check({1'b0, fault, fault_cause}, {1'b0, v.xf, (v.xf ? 6'd18 : 6'd0)}, {tag, " fault/cause"});
        @(posedge clk);
        #1;
        check({4'b0, elp_q, spelp, mpelp, dbg_elp}, {4'b0, v.xe, v.xs, v.xm, v.xd}, {tag, " state"});
    endtask

    task automatic idle();
        insn_valid = 1'b0; insn_word = NOP; priv = 2'd3;
        {lp_en_m, lp_en_s, lp_en_u} = 3'b100;
        jump_valid = 1'b0; jump_rs1 = '0;
        {dbg_enter, trap_m, trap_s, ret_m, ret_s} = '0;
    endtask

    // Watchdog: an expired run counts as one failure.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual expired expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check({4'b0, elp_q, spelp, mpelp, dbg_elp}, 8'h00, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        insn_valid = 1'b1;
        #(CLK_PERIOD/4);
        check({1'b0, fault, fault_cause}, 8'h00, "R1 fault after release");
        @(posedge clk);
        #1;
        check({4'b0, elp_q, spelp, mpelp, dbg_elp}, 8'h00, "R1 state after release");
        idle();

        for (int i = 0; i < NV; i++) step(VEC[i]);

        // R1: reset mid-run clears saved bits (spelp, dbg_elp are 1 here)
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check({4'b0, elp_q, spelp, mpelp, dbg_elp}, 8'h00, "R1 mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R2: label bits ignored; all-ones label still a pad
        step('{4'd5, 1'b1, JR, 2'd3, 3'b100, 1'b1, 5'd9, 5'b00000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0});
        step('{4'd2, 1'b1, 32'hFFFF_F017, 2'd3, 3'b100, 1'b0, 5'd0, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
        // R4: reserved privilege code 2 never enables
        step('{4'd4, 1'b1, JR, 2'd2, 3'b111, 1'b1, 5'd9, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
        // R9: trap_m beats trap_s; spelp untouched
        step('{4'd5, 1'b1, JR, 2'd3, 3'b100, 1'b1, 5'd9, 5'b00000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0});
        step('{4'd9, 1'b1, NOP, 2'd3, 3'b100, 1'b0, 5'd0, 5'b01100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0});
        // R9: ret_m beats ret_s; spelp stays 0, mpelp consumed
        step('{4'd9, 1'b0, NOP, 2'd3, 3'b100, 1'b0, 5'd0, 5'b00011, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0});

        @(negedge clk);
        idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule